// File: doc/BRIEF.md
# Four-Channel Compare and PWM Match Unit

This block sits beside a free-running timer counter and watches its value. Each of four channels holds a compare value. When the count reaches that value the channel can ask the counter to return to zero, ask it to halt, raise a sticky event flag and change its external output bit. Software programs the unit through one write port. The same port loads compare values, loads per-channel option words and clears event flags.

Channels 0 to 2 can also run as pulse-width modulators. In that mode the output is low while the count is below the channel's compare value and high from that value on. The highest channel is reserved as the shared period. Its compare value ends every PWM cycle by asking the counter to reset. That channel cannot itself be put into PWM mode. The counter and any prescaler live outside this block.

Write map: addresses 0 to 3 load the compare value of that channel. Addresses 4 to 7 load the option word of channel (address - 4). Address 8 clears the event flags whose data bits are 1. Option word bits: [0] reset request on match, [1] stop request on match, [2] interrupt enable, [4:3] output action, [5] output value loaded on this write, [6] PWM mode.

Top module: `match_pwm_unit`

## Requirements
- R1: While reset is asserted, the flags, the external bits, the interrupt, and the reset and stop requests are all 0. Compare values and option words reset to 0.
- R2: A channel matches only in the first cycle that the count equals its compare value. A count held at that value does not match again.
- R3: A match sets the channel's flag one clock later, whatever the interrupt enable says. Writing 1 to a flag bit at address 8 clears it. If a match and a clear of the same flag fall in one cycle, the flag stays set.
- R4: `irq_o` is high exactly when some flag is set and that channel's interrupt enable (option bit 2) is 1.
- R5: In the cycle of a match, `cnt_reset_o` goes high without delay when that channel has option bit 0 set.
- R6: In the cycle of a match, `cnt_stop_o` goes high without delay when that channel has option bit 1 set.
- R7: Outside PWM mode, the edge after a match applies the output action code (option bits [4:3]) to the external bit: 0 keeps it, 1 drives it to 0, 2 drives it to 1, 3 inverts it.
- R8: Writing an option word loads option bit 5 into that channel's external bit at the next edge. This takes priority over any action in the same cycle.
- R9: In PWM mode, a channel's external bit becomes (count >= compare value) one clock after the count is presented. A match of channel 3 while any channel is in PWM mode raises `cnt_reset_o`.
- R10: A PWM request in channel 3's option word is discarded. Channel 3 keeps its normal action behaviour.
- R11: When several channels match in the same cycle, all of their flags, actions and requests take effect together.
- R12: A compare value rewritten while running, PWM included, is used for the comparison from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | CW | Current counter value |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | CW | Register write data |
| cnt_reset_o | output | 1 | Request to return the counter to zero (this cycle) |
| cnt_stop_o | output | 1 | Request to halt the counter (this cycle) |
| ext_o | output | NCH | External match output bits |
| flags_o | output | NCH | Sticky match event flags |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions assume the count input is sampled once per clock edge, and that software writes at most one register per cycle. The PWM level check also assumes the option word is not rewritten in the cycle it looks at, and it excludes that cycle. Stimulus keeps counts and compare values in a small range, from 0 to 7, so matches, held counts and PWM crossings happen often. Random writes mix compare values, option words with every action code and the PWM bit, and flag clears. Directed cases cover period wrap, a rejected PWM request on channel 3, simultaneous matches, and a clear that collides with a match.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

   typedef enum logic [1:0] {
      ACT_KEEP   = 2'd0,
      ACT_LOW    = 2'd1,
      ACT_HIGH   = 2'd2,
      ACT_INVERT = 2'd3
   } ext_act_e;

   typedef struct packed {
      logic     pwm;
      logic     init;
      ext_act_e act;
      logic     irq_en;
      logic     stop_en;
      logic     rst_en;
   } chan_cfg_t;

   localparam int CFG_W = 7;

endpackage

// File: rtl/mpu_regfile.sv
module mpu_regfile
   import mpu_pkg::*;
#(
   parameter int NCH = 4,
   parameter int CW  = 32,
   parameter int AW  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en_i,
   input  logic [AW-1:0]           wr_addr_i,
   input  logic [CW-1:0]           wr_data_i,
   output logic [NCH-1:0][CW-1:0]  match_o,
   output chan_cfg_t [NCH-1:0]     cfg_o,
   output logic [NCH-1:0]          cfg_wr_o,
   output logic                    wr_init_o,
   output logic [NCH-1:0]          flag_clr_o
);

   localparam logic [AW-1:0] CLR_ADDR = AW'(2 * NCH);

   assign wr_init_o  = wr_data_i[5];
   assign flag_clr_o = (wr_en_i && wr_addr_i == CLR_ADDR) ? wr_data_i[NCH-1:0] : '0;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam logic [AW-1:0] MADDR  = AW'(i);
      localparam logic [AW-1:0] CADDR  = AW'(NCH + i);
      localparam logic          PWM_OK = (i != NCH - 1);

      logic [CW-1:0] mv_q;
      chan_cfg_t     cfg_q;

      assign cfg_wr_o[i] = wr_en_i && (wr_addr_i == CADDR);
      assign match_o[i]  = mv_q;
      assign cfg_o[i]    = cfg_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mv_q  <= '0;
            cfg_q <= '0;
         end else begin
            if (wr_en_i && wr_addr_i == MADDR) mv_q <= wr_data_i;
            if (cfg_wr_o[i]) begin
               cfg_q <= '{pwm:     wr_data_i[6] & PWM_OK,
                          init:    wr_data_i[5],
                          act:     ext_act_e'(wr_data_i[4:3]),
                          irq_en:  wr_data_i[2],
                          stop_en: wr_data_i[1],
                          rst_en:  wr_data_i[0]};
            end
         end
      end
   end

   // R10: the period channel never holds PWM mode
   assert_period_no_pwm_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_o[NCH-1].pwm);

endmodule

// File: rtl/mpu_chan.sv
module mpu_chan
   import mpu_pkg::*;
#(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count_i,
   input  logic          fresh_i,
   input  logic [CW-1:0] match_i,
   input  chan_cfg_t     cfg_i,
   input  logic          cfg_wr_i,
   input  logic          init_i,
   input  logic          flag_clr_i,
   output logic          hit_o,
   output logic          ext_o,
   output logic          flag_o
);

   assign hit_o = fresh_i && (count_i == match_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_o  <= 1'b0;
         flag_o <= 1'b0;
      end else begin
         flag_o <= hit_o | (flag_o & ~flag_clr_i);
         if (cfg_wr_i) begin
            ext_o <= init_i;
         end else if (cfg_i.pwm) begin
            ext_o <= (count_i >= match_i);
         end else if (hit_o) begin
            case (cfg_i.act)
               ACT_LOW:    ext_o <= 1'b0;
               ACT_HIGH:   ext_o <= 1'b1;
               ACT_INVERT: ext_o <= ~ext_o;
               default:    ext_o <= ext_o;
            endcase
         end
      end
   end

   assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> flag_o);

   assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && !hit_o) |=> !flag_o);

   assert_single_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !(hit_o && count_i == $past(count_i)));

   assert_act_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o && !cfg_i.pwm && cfg_i.act == ACT_HIGH && !cfg_wr_i) |=> ext_o);

   assert_pwm_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.pwm && !cfg_wr_i) |=> (ext_o == ($past(count_i) >= $past(match_i))));

endmodule

// File: rtl/match_pwm_unit.sv
module match_pwm_unit
   import mpu_pkg::*;
#(
   parameter int   NCH = 4,
   parameter int   CW  = 32,
   localparam int  AW  = $clog2(2 * NCH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [CW-1:0]  count_i,
   input  logic           wr_en_i,
   input  logic [AW-1:0]  wr_addr_i,
   input  logic [CW-1:0]  wr_data_i,
   output logic           cnt_reset_o,
   output logic           cnt_stop_o,
   output logic [NCH-1:0] ext_o,
   output logic [NCH-1:0] flags_o,
   output logic           irq_o
);

   if (NCH < 2) begin : g_bad_nch
      $error("match_pwm_unit: NCH must be at least 2");
   end
   if (CW < CFG_W || CW < NCH) begin : g_bad_cw
      $error("match_pwm_unit: CW too narrow for option word or flag clear");
   end

   logic [NCH-1:0][CW-1:0] match_v;
   chan_cfg_t [NCH-1:0]    cfg_v;
   logic [NCH-1:0]         cfg_wr;
   logic [NCH-1:0]         flag_clr;
   logic [NCH-1:0]         hit;
   logic [NCH-1:0]         rst_en, stop_en, irq_en, pwm_en;
   logic                   wr_init;
   logic [CW-1:0]          prev_cnt;
   logic                   prev_vld;
   logic                   fresh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_cnt <= '0;
         prev_vld <= 1'b0;
      end else begin
         prev_cnt <= count_i;
         prev_vld <= 1'b1;
      end
   end

   assign fresh = !prev_vld || (count_i != prev_cnt);

   mpu_regfile #(.NCH(NCH), .CW(CW), .AW(AW)) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .match_o    (match_v),
      .cfg_o      (cfg_v),
      .cfg_wr_o   (cfg_wr),
      .wr_init_o  (wr_init),
      .flag_clr_o (flag_clr)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      assign rst_en[i]  = cfg_v[i].rst_en;
      assign stop_en[i] = cfg_v[i].stop_en;
      assign irq_en[i]  = cfg_v[i].irq_en;
      assign pwm_en[i]  = cfg_v[i].pwm;

      mpu_chan #(.CW(CW)) i_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .count_i    (count_i),
         .fresh_i    (fresh),
         .match_i    (match_v[i]),
         .cfg_i      (cfg_v[i]),
         .cfg_wr_i   (cfg_wr[i]),
         .init_i     (wr_init),
         .flag_clr_i (flag_clr[i]),
         .hit_o      (hit[i]),
         .ext_o      (ext_o[i]),
         .flag_o     (flags_o[i])
      );
   end

   assign cnt_reset_o = (|(hit & rst_en)) | (hit[NCH-1] & (|pwm_en));
   assign cnt_stop_o  = |(hit & stop_en);
   assign irq_o       = |(flags_o & irq_en);

   // R9: a period match with PWM active always asks for a counter reset
   assert_period_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (count_i == match_v[NCH-1] && fresh && (|pwm_en)) |-> cnt_reset_o);

   // R4: no interrupt while every flag is clear
   assert_irq_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o == '0) |-> !irq_o);

endmodule

// File: tb/test_match_pwm_unit.sv
module test_match_pwm_unit;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int CW  = 32;
   localparam int AW  = $clog2(2 * NCH + 1);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [CW-1:0]  count = '0;
   logic           wr_en = 1'b0;
   logic [AW-1:0]  wr_addr = '0;
   logic [CW-1:0]  wr_data = '0;
   logic           cnt_reset_o, cnt_stop_o, irq_o;
   logic [NCH-1:0] ext_o, flags_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [CW-1:0] m_mr  [NCH];
   logic [6:0]    m_cfg [NCH];
   logic [NCH-1:0] m_ext, m_flag;
   logic [CW-1:0] m_pc;
   logic          m_pv;

   always #(CLK_PERIOD / 2) clk = ~clk;

   match_pwm_unit #(.NCH(NCH), .CW(CW)) i_match_pwm_unit (
      .clk(clk), .rst_n(rst_n), .count_i(count), .wr_en_i(wr_en),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .cnt_reset_o(cnt_reset_o),
      .cnt_stop_o(cnt_stop_o), .ext_o(ext_o), .flags_o(flags_o), .irq_o(irq_o));

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [NCH-1:0] exp_irq();
      logic [NCH-1:0] r;
      for (int i = 0; i < NCH; i++) r[i] = m_flag[i] & m_cfg[i][2];
      return r;
   endfunction

   task automatic step(input logic [CW-1:0] cnt, input logic we, input logic [AW-1:0] a,
                       input logic [CW-1:0] d, input string tag);
      logic [NCH-1:0] hit;
      logic er, es, anyp, clr;
      count = cnt; wr_en = we; wr_addr = a; wr_data = d;
      #1;
      anyp = 1'b0; er = 1'b0; es = 1'b0;
      for (int i = 0; i < NCH; i++) begin
         anyp |= m_cfg[i][6];
         hit[i] = (cnt == m_mr[i]) && !(m_pv && cnt == m_pc);
      end
      for (int i = 0; i < NCH; i++) begin
         er |= hit[i] & m_cfg[i][0];
         es |= hit[i] & m_cfg[i][1];
      end
      er |= hit[NCH-1] & anyp;
      chk(32'(cnt_reset_o), 32'(er), tag, "cnt_reset_o");
      chk(32'(cnt_stop_o), 32'(es), tag, "cnt_stop_o");
      @(posedge clk);
      for (int i = 0; i < NCH; i++) begin
         clr = we && a == AW'(2 * NCH) && d[i];
         m_flag[i] = hit[i] | (m_flag[i] & ~clr);
         if (we && a == AW'(NCH + i)) m_ext[i] = d[5];
         else if (m_cfg[i][6]) m_ext[i] = (cnt >= m_mr[i]);
         else if (hit[i]) begin
            case (m_cfg[i][4:3])
               2'd1: m_ext[i] = 1'b0;
               2'd2: m_ext[i] = 1'b1;
               2'd3: m_ext[i] = ~m_ext[i];
               default: ;
            endcase
         end
      end
      for (int i = 0; i < NCH; i++) begin
         if (we && a == AW'(i)) m_mr[i] = d;
         if (we && a == AW'(NCH + i)) begin
            m_cfg[i] = d[6:0];
            if (i == NCH - 1) m_cfg[i][6] = 1'b0;
         end
      end
      m_pc = cnt; m_pv = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk(32'(ext_o), 32'(m_ext), tag, "ext_o");
      chk(32'(flags_o), 32'(m_flag), tag, "flags_o");
      chk(32'(irq_o), 32'(|exp_irq()), tag, "irq_o");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd24681));
      for (int i = 0; i < NCH; i++) begin m_mr[i] = '0; m_cfg[i] = '0; end
      m_ext = '0; m_flag = '0; m_pc = '0; m_pv = 1'b0;
      count = 100;
      repeat (2) @(negedge clk);
      // R1: reset values
      chk(32'(ext_o), 0, "R1", "ext_o");
      chk(32'(flags_o), 0, "R1", "flags_o");
      chk(32'(irq_o), 0, "R1", "irq_o");
      chk(32'(cnt_reset_o | cnt_stop_o), 0, "R1", "requests");
      rst_n = 1'b1;

      step(100, 1, 4, 32'h20, "R8");           // init value 1 on ch0
      step(100, 1, 1, 5, "R12");
      step(100, 1, 5, 32'h1C, "R7");           // ch1: invert, irq enabled
      step(5, 0, 0, 0, "R7");                  // match inverts ext1, flag1, irq
      step(5, 0, 0, 0, "R2");                  // held count: no second match
      step(5, 1, 8, 32'h2, "R3");              // clear flag1
      step(5, 0, 0, 0, "R2");
      step(100, 1, 2, 9, "R5");
      step(100, 1, 6, 32'h3, "R6");            // ch2: reset + stop
      step(9, 0, 0, 0, "R5");
      step(100, 1, 0, 20, "R11");
      step(100, 1, 1, 20, "R11");
      step(20, 0, 0, 0, "R11");                // ch0 and ch1 together
      step(100, 1, 7, 32'h50, "R10");          // ch3: PWM request + action high
      step(100, 1, 3, 50, "R10");
      step(50, 0, 0, 0, "R10");
      step(49, 0, 0, 0, "R10");                // stays 1, not a PWM level
      step(100, 1, 3, 7, "R9");
      step(100, 1, 0, 3, "R9");
      step(100, 1, 4, 32'h40, "R9");           // ch0 PWM mode
      for (int c = 0; c < 8; c++) step(CW'(c), 0, 0, 0, "R9");
      step(0, 1, 0, 5, "R12");                 // new pulse width while running
      for (int c = 1; c < 8; c++) step(CW'(c), 0, 0, 0, "R12");
      step(100, 1, 4, 32'h04, "R4");           // ch0 normal, irq enabled
      step(100, 1, 8, 32'hF, "R3");
      step(100, 0, 0, 0, "R4");
      step(5, 0, 0, 0, "R4");
      step(6, 1, 8, 32'hF, "R3");
      step(5, 1, 8, 32'h1, "R3");              // match and clear collide
      for (int n = 0; n < 3000; n++) begin
         logic [AW-1:0] a;
         logic [CW-1:0] d;
         logic we;
         we = ($urandom_range(0, 2) == 0);
         a = AW'($urandom_range(0, 2 * NCH));
         if (a < AW'(NCH)) d = CW'($urandom_range(0, 7));
         else d = CW'($urandom_range(0, 127));
         step(CW'($urandom_range(0, 7)), we, a, d, "R11 random");
      end
      finish_run();
   end

endmodule